// File: doc/BRIEF.md
# Pipeline Stage Barrier Set

This block holds the four inter-stage barriers of a five-stage in-order 32-bit integer datapath: fetch-to-decode, decode-to-execute, execute-to-memory and memory-to-writeback. It also holds the fetch program counter. Each barrier keeps its lanes from one cycle to the next. The instruction memory and data memory are synchronous and already take one cycle to return a word. For that reason the instruction lane of the fetch barrier and the read-data lane of the writeback barrier are wires, while every other lane is a register. The write port of the register file is driven only from control fields that have been carried down to the writeback stage.

The datapath is run with four no-operation instructions between each pair of real instructions, so at most one real instruction is in flight at a time. Hazard detection, forwarding, stalls and flushes are therefore not part of this block. The stage lanes are free-running and have no valid/ready handshake. No stage can stall, so every lane advances on every clock. Reset is synchronous and active high.

Top module: `pipe_barrier_set`

## Requirements
- R1: While reset is high the fetch PC `fetch_pc_o` is 0. After reset falls it grows by 4 on every rising clock edge.
- R2: `dec_pc_o` equals the value `fetch_pc_o` had in the previous cycle.
- R3: `dec_insn_o` equals `fet_insn_i` in the same cycle, with no register in between. The no-operation word 0x00000013 passes unchanged.
- R4: Every decode-to-execute lane is delayed by exactly one clock. These lanes are PC, both operand values, the immediate, the 4-bit ALU op code, both operand selects, the memory read and write flags, the 5-bit destination and the write enable.
- R5: Every execute-to-memory lane is delayed by exactly one clock. These lanes are the ALU result, the store data, the memory read and write flags, the destination and the write enable.
- R6: The writeback lanes for ALU result, load flag, destination and write enable are delayed by one clock. `wb_load_o` equals `mw_load_i` in the same cycle.
- R7: `wb_data_o` is `wb_load_o` when `wb_is_load_o` is 1, and `wb_alu_o` otherwise. The register write address and enable are the registered writeback lanes `wb_rd_o` and `wb_we_o`.
- R8: A rising edge with reset high clears every registered lane to zero, including all write enables.
- R9: A write enable that arrives with destination 0 is dropped. `wb_we_o` is never 1 while `wb_rd_o` is 0, so a no-operation has no architectural effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc_o | output | 32 | Fetch PC, used as the instruction memory address |
| fet_insn_i | input | 32 | Instruction word from the instruction memory |
| dec_pc_o | output | 32 | PC of the instruction in decode |
| dec_insn_o | output | 32 | Instruction in decode (passthrough) |
| dx_pc_i | input | 32 | Decode PC into the execute barrier |
| dx_rs1_i | input | 32 | First operand value |
| dx_rs2_i | input | 32 | Second operand value |
| dx_imm_i | input | 32 | Decoded immediate |
| dx_aluop_i | input | 4 | ALU op code |
| dx_asel_i | input | 1 | First operand select |
| dx_bsel_i | input | 1 | Second operand select |
| dx_mrd_i | input | 1 | Memory read flag |
| dx_mwr_i | input | 1 | Memory write flag |
| dx_rd_i | input | 5 | Destination register |
| dx_we_i | input | 1 | Register write enable |
| ex_pc_o | output | 32 | Registered PC |
| ex_rs1_o | output | 32 | Registered first operand |
| ex_rs2_o | output | 32 | Registered second operand |
| ex_imm_o | output | 32 | Registered immediate |
| ex_aluop_o | output | 4 | Registered ALU op code |
| ex_asel_o | output | 1 | Registered first operand select |
| ex_bsel_o | output | 1 | Registered second operand select |
| ex_mrd_o | output | 1 | Registered memory read flag |
| ex_mwr_o | output | 1 | Registered memory write flag |
| ex_rd_o | output | 5 | Registered destination |
| ex_we_o | output | 1 | Registered write enable |
| xm_alu_i | input | 32 | ALU result |
| xm_sdata_i | input | 32 | Store data |
| xm_mrd_i | input | 1 | Memory read flag |
| xm_mwr_i | input | 1 | Memory write flag |
| xm_rd_i | input | 5 | Destination |
| xm_we_i | input | 1 | Write enable |
| mem_alu_o | output | 32 | Registered ALU result, used as the data address |
| mem_sdata_o | output | 32 | Registered store data |
| mem_mrd_o | output | 1 | Registered memory read flag |
| mem_mwr_o | output | 1 | Registered memory write flag |
| mem_rd_o | output | 5 | Registered destination |
| mem_we_o | output | 1 | Registered write enable |
| mw_alu_i | input | 32 | ALU result into the writeback barrier |
| mw_load_i | input | 32 | Data memory read word |
| mw_isld_i | input | 1 | Instruction is a load |
| mw_rd_i | input | 5 | Destination |
| mw_we_i | input | 1 | Write enable |
| wb_alu_o | output | 32 | Registered ALU result |
| wb_load_o | output | 32 | Load word (passthrough) |
| wb_is_load_o | output | 1 | Registered load flag |
| wb_rd_o | output | 5 | Register file write address |
| wb_we_o | output | 1 | Register file write enable |
| wb_data_o | output | 32 | Register file write data |

## Verification
A lane that holds a stale or uncleared value shows up at its output port on the first rising edge after the stimulus. It appears either as the previous pattern still present or as a nonzero value right after reset. A lane that was wrongly registered instead of wired shows up within the same cycle, because the passthrough output then lags its input. A dropped x0 filter or a wrong writeback select is visible on `wb_we_o` or `wb_data_o` one edge after the writeback inputs change.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int XLEN  = 32;
  localparam int RAW   = 5;
  localparam int AOPW  = 4;
  localparam int PCSTP = 4;

  typedef struct packed {
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] rs1;
    logic [XLEN-1:0] rs2;
    logic [XLEN-1:0] imm;
    logic [AOPW-1:0] aluop;
    logic            asel;
    logic            bsel;
    logic            mrd;
    logic            mwr;
    logic [RAW-1:0]  rd;
    logic            we;
  } dx_lane_t;

  typedef struct packed {
    logic [XLEN-1:0] alu;
    logic [XLEN-1:0] sdata;
    logic            mrd;
    logic            mwr;
    logic [RAW-1:0]  rd;
    logic            we;
  } xm_lane_t;

  typedef struct packed {
    logic [XLEN-1:0] alu;
    logic            isld;
    logic [RAW-1:0]  rd;
    logic            we;
  } mw_lane_t;
endpackage

// File: rtl/pbs_lane.sv
module pbs_lane #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] r;
  always_ff @(posedge clk) begin
    if (rst) r <= '0;
    else     r <= d;
  end
  assign q = r;
endmodule

// File: rtl/pbs_fetch_dec.sv
module pbs_fetch_dec
  import pbs_pkg::*;
#(
  parameter int W    = XLEN,
  parameter int STEP = PCSTP
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] insn_i,
  output logic [W-1:0] pc_o,
  output logic [W-1:0] dpc_o,
  output logic [W-1:0] dinsn_o
);
  logic [W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_q + W'(STEP);
  end
  assign pc_o = pc_q;

  pbs_lane #(.W(W)) u_pc_lane (.clk(clk), .rst(rst), .d(pc_q), .q(dpc_o));

  // Instruction memory already spends a cycle; no register here.
  assign dinsn_o = insn_i;

  logic chk_live_q;
  always_ff @(posedge clk) begin
    if (rst) chk_live_q <= 1'b1;
  end

  a_r1_pc_step: assert property (@(posedge clk) disable iff (rst)
    (chk_live_q === 1'b1 && !$past(rst)) |-> pc_q == $past(pc_q) + W'(STEP));
  a_r2_pc_lag: assert property (@(posedge clk) disable iff (rst)
    (chk_live_q === 1'b1 && !$past(rst)) |-> dpc_o == $past(pc_o));
  a_r8_pc_clear: assert property (@(posedge clk) disable iff (rst)
    (chk_live_q === 1'b1 && $past(rst)) |-> (pc_q == '0 && dpc_o == '0));
endmodule

// File: rtl/pbs_dec_ex.sv
module pbs_dec_ex
  import pbs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  dx_lane_t d_i,
  output dx_lane_t q_o
);
  localparam int LW = $bits(dx_lane_t);
  logic [LW-1:0] q_raw;

  pbs_lane #(.W(LW)) u_dx (.clk(clk), .rst(rst), .d(d_i), .q(q_raw));
  assign q_o = dx_lane_t'(q_raw);

  logic chk_live_q;
  always_ff @(posedge clk) begin
    if (rst) chk_live_q <= 1'b1;
  end

  a_r4_dx_delay: assert property (@(posedge clk) disable iff (rst)
    (chk_live_q === 1'b1 && !$past(rst)) |-> (q_o.rd == $past(d_i.rd) && q_o.we == $past(d_i.we)));
  a_r8_dx_clear: assert property (@(posedge clk) disable iff (rst)
    (chk_live_q === 1'b1 && $past(rst)) |-> (!q_o.we && !q_o.mwr && !q_o.mrd));
endmodule

// File: rtl/pbs_ex_mem.sv
module pbs_ex_mem
  import pbs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  xm_lane_t d_i,
  output xm_lane_t q_o
);
  localparam int LW = $bits(xm_lane_t);
  logic [LW-1:0] q_raw;

  pbs_lane #(.W(LW)) u_xm (.clk(clk), .rst(rst), .d(d_i), .q(q_raw));
  assign q_o = xm_lane_t'(q_raw);

  logic chk_live_q;
  always_ff @(posedge clk) begin
    if (rst) chk_live_q <= 1'b1;
  end

  a_r5_xm_delay: assert property (@(posedge clk) disable iff (rst)
    (chk_live_q === 1'b1 && !$past(rst)) |-> (q_o.alu == $past(d_i.alu) && q_o.mwr == $past(d_i.mwr)));
  a_r8_xm_clear: assert property (@(posedge clk) disable iff (rst)
    (chk_live_q === 1'b1 && $past(rst)) |-> (!q_o.we && !q_o.mwr && !q_o.mrd));
endmodule

// File: rtl/pbs_mem_wb.sv
module pbs_mem_wb
  import pbs_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  mw_lane_t        d_i,
  input  logic [XLEN-1:0] load_i,
  output mw_lane_t        q_o,
  output logic [XLEN-1:0] load_o,
  output logic [XLEN-1:0] data_o
);
  localparam int LW = $bits(mw_lane_t);
  mw_lane_t      d_gated;
  logic [LW-1:0] q_raw;

  // A write aimed at register 0 is dropped before it is stored.
  always_comb begin
    d_gated    = d_i;
    d_gated.we = d_i.we && (d_i.rd != '0);
  end

  pbs_lane #(.W(LW)) u_mw (.clk(clk), .rst(rst), .d(d_gated), .q(q_raw));
  assign q_o = mw_lane_t'(q_raw);

  // Data memory read is already one cycle late; pass it straight on.
  assign load_o = load_i;
  assign data_o = q_o.isld ? load_i : q_o.alu;

  logic chk_live_q;
  always_ff @(posedge clk) begin
    if (rst) chk_live_q <= 1'b1;
  end

  a_r9_no_x0_write: assert property (@(posedge clk) disable iff (rst)
    q_o.we |-> q_o.rd != '0);
  a_r6_mw_delay: assert property (@(posedge clk) disable iff (rst)
    (chk_live_q === 1'b1 && !$past(rst)) |-> (q_o.alu == $past(d_i.alu) && q_o.rd == $past(d_i.rd)));
  a_r8_mw_clear: assert property (@(posedge clk) disable iff (rst)
    (chk_live_q === 1'b1 && $past(rst)) |-> (!q_o.we && q_o.alu == '0));
endmodule

// File: rtl/pipe_barrier_set.sv
module pipe_barrier_set
  import pbs_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] fetch_pc_o,
  input  logic [XLEN-1:0] fet_insn_i,
  output logic [XLEN-1:0] dec_pc_o,
  output logic [XLEN-1:0] dec_insn_o,
  input  logic [XLEN-1:0] dx_pc_i,
  input  logic [XLEN-1:0] dx_rs1_i,
  input  logic [XLEN-1:0] dx_rs2_i,
  input  logic [XLEN-1:0] dx_imm_i,
  input  logic [AOPW-1:0] dx_aluop_i,
  input  logic            dx_asel_i,
  input  logic            dx_bsel_i,
  input  logic            dx_mrd_i,
  input  logic            dx_mwr_i,
  input  logic [RAW-1:0]  dx_rd_i,
  input  logic            dx_we_i,
  output logic [XLEN-1:0] ex_pc_o,
  output logic [XLEN-1:0] ex_rs1_o,
  output logic [XLEN-1:0] ex_rs2_o,
  output logic [XLEN-1:0] ex_imm_o,
  output logic [AOPW-1:0] ex_aluop_o,
  output logic            ex_asel_o,
  output logic            ex_bsel_o,
  output logic            ex_mrd_o,
  output logic            ex_mwr_o,
  output logic [RAW-1:0]  ex_rd_o,
  output logic            ex_we_o,
  input  logic [XLEN-1:0] xm_alu_i,
  input  logic [XLEN-1:0] xm_sdata_i,
  input  logic            xm_mrd_i,
  input  logic            xm_mwr_i,
  input  logic [RAW-1:0]  xm_rd_i,
  input  logic            xm_we_i,
  output logic [XLEN-1:0] mem_alu_o,
  output logic [XLEN-1:0] mem_sdata_o,
  output logic            mem_mrd_o,
  output logic            mem_mwr_o,
  output logic [RAW-1:0]  mem_rd_o,
  output logic            mem_we_o,
  input  logic [XLEN-1:0] mw_alu_i,
  input  logic [XLEN-1:0] mw_load_i,
  input  logic            mw_isld_i,
  input  logic [RAW-1:0]  mw_rd_i,
  input  logic            mw_we_i,
  output logic [XLEN-1:0] wb_alu_o,
  output logic [XLEN-1:0] wb_load_o,
  output logic            wb_is_load_o,
  output logic [RAW-1:0]  wb_rd_o,
  output logic            wb_we_o,
  output logic [XLEN-1:0] wb_data_o
);
  dx_lane_t dx_d, dx_q;
  xm_lane_t xm_d, xm_q;
  mw_lane_t mw_d, mw_q;

  pbs_fetch_dec u_fd (
    .clk(clk), .rst(rst), .insn_i(fet_insn_i),
    .pc_o(fetch_pc_o), .dpc_o(dec_pc_o), .dinsn_o(dec_insn_o)
  );

  always_comb begin
    dx_d.pc    = dx_pc_i;
    dx_d.rs1   = dx_rs1_i;
    dx_d.rs2   = dx_rs2_i;
    dx_d.imm   = dx_imm_i;
    dx_d.aluop = dx_aluop_i;
    dx_d.asel  = dx_asel_i;
    dx_d.bsel  = dx_bsel_i;
    dx_d.mrd   = dx_mrd_i;
    dx_d.mwr   = dx_mwr_i;
    dx_d.rd    = dx_rd_i;
    dx_d.we    = dx_we_i;
  end

  pbs_dec_ex u_dx (.clk(clk), .rst(rst), .d_i(dx_d), .q_o(dx_q));

  assign ex_pc_o    = dx_q.pc;
  assign ex_rs1_o   = dx_q.rs1;
  assign ex_rs2_o   = dx_q.rs2;
  assign ex_imm_o   = dx_q.imm;
  assign ex_aluop_o = dx_q.aluop;
  assign ex_asel_o  = dx_q.asel;
  assign ex_bsel_o  = dx_q.bsel;
  assign ex_mrd_o   = dx_q.mrd;
  assign ex_mwr_o   = dx_q.mwr;
  assign ex_rd_o    = dx_q.rd;
  assign ex_we_o    = dx_q.we;

  always_comb begin
    xm_d.alu   = xm_alu_i;
    xm_d.sdata = xm_sdata_i;
    xm_d.mrd   = xm_mrd_i;
    xm_d.mwr   = xm_mwr_i;
    xm_d.rd    = xm_rd_i;
    xm_d.we    = xm_we_i;
  end

  pbs_ex_mem u_xm (.clk(clk), .rst(rst), .d_i(xm_d), .q_o(xm_q));

  assign mem_alu_o   = xm_q.alu;
  assign mem_sdata_o = xm_q.sdata;
  assign mem_mrd_o   = xm_q.mrd;
  assign mem_mwr_o   = xm_q.mwr;
  assign mem_rd_o    = xm_q.rd;
  assign mem_we_o    = xm_q.we;

  always_comb begin
    mw_d.alu  = mw_alu_i;
    mw_d.isld = mw_isld_i;
    mw_d.rd   = mw_rd_i;
    mw_d.we   = mw_we_i;
  end

  pbs_mem_wb u_mw (
    .clk(clk), .rst(rst), .d_i(mw_d), .load_i(mw_load_i),
    .q_o(mw_q), .load_o(wb_load_o), .data_o(wb_data_o)
  );

  assign wb_alu_o     = mw_q.alu;
  assign wb_is_load_o = mw_q.isld;
  assign wb_rd_o      = mw_q.rd;
  assign wb_we_o      = mw_q.we;
endmodule

// File: tb/pipe_barrier_set_tb_top.sv
`timescale 1ns/1ps
module pipe_barrier_set_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] fetch_pc_o, fet_insn_i, dec_pc_o, dec_insn_o;
  logic [31:0] dx_pc_i, dx_rs1_i, dx_rs2_i, dx_imm_i;
  logic [3:0]  dx_aluop_i;
  logic        dx_asel_i, dx_bsel_i, dx_mrd_i, dx_mwr_i, dx_we_i;
  logic [4:0]  dx_rd_i;
  logic [31:0] ex_pc_o, ex_rs1_o, ex_rs2_o, ex_imm_o;
  logic [3:0]  ex_aluop_o;
  logic        ex_asel_o, ex_bsel_o, ex_mrd_o, ex_mwr_o, ex_we_o;
  logic [4:0]  ex_rd_o;
  logic [31:0] xm_alu_i, xm_sdata_i;
  logic        xm_mrd_i, xm_mwr_i, xm_we_i;
  logic [4:0]  xm_rd_i;
  logic [31:0] mem_alu_o, mem_sdata_o;
  logic        mem_mrd_o, mem_mwr_o, mem_we_o;
  logic [4:0]  mem_rd_o;
  logic [31:0] mw_alu_i, mw_load_i;
  logic        mw_isld_i, mw_we_i;
  logic [4:0]  mw_rd_i;
  logic [31:0] wb_alu_o, wb_load_o, wb_data_o;
  logic        wb_is_load_o, wb_we_o;
  logic [4:0]  wb_rd_o;

  pipe_barrier_set dut_i (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edge_settle();
    @(posedge clk); #1;
  endtask

  task automatic drive_dx(input logic [31:0] base, input logic [4:0] rd, input logic fl);
    dx_pc_i = base; dx_rs1_i = base ^ 32'h1111_0000; dx_rs2_i = base + 32'd7;
    dx_imm_i = ~base; dx_aluop_i = base[3:0]; dx_asel_i = fl; dx_bsel_i = ~fl;
    dx_mrd_i = fl; dx_mwr_i = ~fl; dx_rd_i = rd; dx_we_i = fl;
  endtask

  task automatic t_reset();
    // R8: nonzero inputs while reset is held must leave registered lanes at zero
    fet_insn_i = 32'hDEAD_BEEF;
    drive_dx(32'hA5A5_0001, 5'd9, 1'b1);
    xm_alu_i = 32'h1234_5678; xm_sdata_i = 32'h8765_4321; xm_mrd_i = 1; xm_mwr_i = 1;
    xm_rd_i = 5'd3; xm_we_i = 1;
    mw_alu_i = 32'hCAFE_0000; mw_load_i = 32'h0; mw_isld_i = 0; mw_rd_i = 5'd4; mw_we_i = 1;
    repeat (3) edge_settle();
    chk("R8 ex_we", {31'd0, ex_we_o}, 32'd0);
    chk("R8 ex_pc", ex_pc_o, 32'd0);
    chk("R8 mem_alu", mem_alu_o, 32'd0);
    chk("R8 mem_mwr", {31'd0, mem_mwr_o}, 32'd0);
    chk("R8 wb_we", {31'd0, wb_we_o}, 32'd0);
    chk("R8 dec_pc", dec_pc_o, 32'd0);
    chk("R1 pc in reset", fetch_pc_o, 32'd0);
  endtask

  task automatic t_pc_run();
    @(negedge clk); rst = 1'b0; #1;
    chk("R1 pc after release", fetch_pc_o, 32'd0);
    for (int k = 1; k <= 4; k++) begin
      edge_settle();
      chk("R1 pc step", fetch_pc_o, 32'(4 * k));
      chk("R2 dec pc lag", dec_pc_o, 32'(4 * (k - 1)));
    end
  endtask

  task automatic t_insn_pass();
    @(negedge clk); fet_insn_i = 32'h0000_0013; #1;
    chk("R3 nop passthrough", dec_insn_o, 32'h0000_0013);
    #0.5 fet_insn_i = 32'h00A0_0093; #0.2;
    chk("R3 same-cycle change", dec_insn_o, 32'h00A0_0093);
  endtask

  task automatic t_dec_ex();
    @(negedge clk); drive_dx(32'h0000_0100, 5'd5, 1'b1);
    edge_settle();
    @(negedge clk); drive_dx(32'h0000_0200, 5'd17, 1'b0); #0.5;
    chk("R4 held before edge rd", {27'd0, ex_rd_o}, 32'd5);
    edge_settle();
    chk("R4 pc", ex_pc_o, 32'h0000_0200);
    chk("R4 rs1", ex_rs1_o, 32'h1111_0200);
    chk("R4 rs2", ex_rs2_o, 32'h0000_0207);
    chk("R4 imm", ex_imm_o, 32'hFFFF_FDFF);
    chk("R4 ctl", {22'd0, ex_aluop_o, ex_asel_o, ex_bsel_o, ex_mrd_o, ex_mwr_o, ex_we_o, 1'b0},
        {22'd0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0});
    chk("R4 rd", {27'd0, ex_rd_o}, 32'd17);
  endtask

  task automatic t_ex_mem();
    @(negedge clk);
    xm_alu_i = 32'h0000_0040; xm_sdata_i = 32'h5555_AAAA; xm_mrd_i = 0; xm_mwr_i = 1;
    xm_rd_i = 5'd0; xm_we_i = 0;
    edge_settle();
    @(negedge clk);
    xm_alu_i = 32'h0000_0080; xm_sdata_i = 32'h0; xm_mrd_i = 1; xm_mwr_i = 0;
    xm_rd_i = 5'd12; xm_we_i = 1; #0.5;
    chk("R5 held before edge", mem_alu_o, 32'h0000_0040);
    chk("R5 store data", mem_sdata_o, 32'h5555_AAAA);
    edge_settle();
    chk("R5 alu", mem_alu_o, 32'h0000_0080);
    chk("R5 ctl", {24'd0, mem_mrd_o, mem_mwr_o, mem_we_o, mem_rd_o}, {24'd0, 1'b1, 1'b0, 1'b1, 5'd12});
  endtask

  task automatic t_mem_wb();
    @(negedge clk);
    mw_alu_i = 32'h0000_0777; mw_isld_i = 0; mw_rd_i = 5'd7; mw_we_i = 1;
    mw_load_i = 32'h1357_9BDF; #0.5;
    chk("R6 load passthrough", wb_load_o, 32'h1357_9BDF);
    edge_settle();
    chk("R6 alu delayed", wb_alu_o, 32'h0000_0777);
    chk("R6 rd/we", {26'd0, wb_we_o, wb_rd_o}, {26'd0, 1'b1, 5'd7});
    chk("R7 data from alu", wb_data_o, 32'h0000_0777);
    @(negedge clk);
    mw_alu_i = 32'h0000_0010; mw_isld_i = 1; mw_rd_i = 5'd8; mw_we_i = 1;
    edge_settle();
    chk("R6 load flag delayed", {31'd0, wb_is_load_o}, 32'd1);
    #0.5 mw_load_i = 32'h2468_ACE0; #0.2;
    chk("R7 data from load", wb_data_o, 32'h2468_ACE0);
    chk("R7 write addr", {27'd0, wb_rd_o}, 32'd8);
  endtask

  task automatic t_x0_drop();
    // R9: NOP 0x00000013 writes x0 with enable set; it must not reach the write port
    @(negedge clk);
    mw_alu_i = 32'h0; mw_isld_i = 0; mw_rd_i = 5'd0; mw_we_i = 1;
    edge_settle();
    chk("R9 x0 write dropped", {31'd0, wb_we_o}, 32'd0);
    chk("R9 rd zero", {27'd0, wb_rd_o}, 32'd0);
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    mw_rd_i = 5'd3; mw_we_i = 1; drive_dx(32'h0000_0300, 5'd6, 1'b1);
    edge_settle();
    @(negedge clk); rst = 1'b1;
    edge_settle();
    chk("R8 mid reset wb_we", {31'd0, wb_we_o}, 32'd0);
    chk("R8 mid reset ex_rd", {27'd0, ex_rd_o}, 32'd0);
    chk("R8 mid reset pc", fetch_pc_o, 32'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_pc_run();
    t_insn_pass();
    t_dec_ex();
    t_ex_mem();
    t_mem_wb();
    t_x0_drop();
    t_mid_reset();
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule